// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block sits between an on-chip host and an external asynchronous static RAM of 65,536 sixteen-bit words. The host raises a request with a word address, write data, a per-lane mask and a read/write flag. It holds all of these steady until the controller returns a single-cycle acknowledge. On a read, the returned data appears on the read-data output in the same cycle as that acknowledge.

On the memory side the controller drives the address, chip enable, output enable, write enable and two active-low lane enables, and it shares a tri-stated 16-bit data bus with the memory. All memory timing is produced by counting clock cycles. Every count is the ceiling of a nanosecond parameter divided by the clock period, so the controller can be retimed for another clock or speed grade by changing parameters only.

A write is split into two phases. In the first phase the write strobe is low and the controller keeps its drivers off, so the memory has time to release the bus. In the second phase the controller drives the bus. The strobe, chip enable, lane enables and drivers are all released together on one clock edge, and that edge ends the write. Between accesses chip enable stays high, which lets the memory enter its low-power state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low, and on the cycle after reset is sampled low, chip enable, output enable and write enable are high, both lane enables are high, acknowledge is low and read data is zero. This holds even if an access was in progress.
- R2: A read with `host_mask` = 2'b11 returns the addressed word on `host_rdata` in the acknowledge cycle.
- R3: On a read, a lane whose mask bit is 0 keeps its previous `host_rdata` value. Bit 0 of the mask selects data bits 7:0 and bit 1 selects bits 15:8. A mask bit of 1 means the lane is enabled.
- R4: A write changes only the memory lanes whose mask bit is 1. `mem_lane_n` bit 0 (low byte) and bit 1 (high byte) are driven low only for enabled lanes.
- R5: During a write, write enable stays low for at least ceil(T_PWE_NS/CLK_NS) cycles, and chip enable is low for all of those cycles.
- R6: During a read, chip enable and output enable stay low with write enable high for at least ceil(T_AA_NS/CLK_NS) cycles.
- R7: The controller drives the data bus only while write enable is low and output enable is high, and only after write enable has been low for ceil(T_HZWE_NS/CLK_NS) cycles. It stops driving on the edge where write enable rises. The bus carries the write data in the last write-enable-low cycle.
- R8: A request with mask 2'b00 is acknowledged without chip enable, output enable, write enable or any lane enable going low.
- R9: Output enable and write enable are never low together. At least one cycle with output enable high separates the end of a read from the start of a write. Chip enable is high whenever no access is in progress.
- R10: Each request receives exactly one acknowledge, lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane enable mask, bit 0 = bits 7:0 |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid in the acknowledge cycle |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq | inout | 16 | Shared data bus |

## Verification
The assertions assume the host keeps address, mask, write data and direction unchanged from the raise of the request until the acknowledge, and drops the request no later than the cycle after the acknowledge. They also assume the memory drives the bus only while it is in a read. The bench drives requests on the falling edge and holds them until it sees the acknowledge. Its memory model drives a lane only while chip enable and output enable are low, write enable is high and that lane is enabled. The one place the bench breaks this contract is the reset-during-write case, where reset overrides it.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and cycle-count helpers for the asynchronous SRAM controller.
// Assumes all nanosecond values and the clock period are positive integers.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WTURN,
        ST_WDRIVE,
        ST_ACK
    } ctrl_state_e;

    // Ceiling of ns over the clock period, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
// Loadable down-counter that times one strobe phase.
// `last` is high during the final cycle of a loaded interval.
// Assumes load_val is nonzero whenever load is high.
module sram_cyc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt;

    // Load a new interval, or count down toward zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Final cycle of the interval.
    assign last = (cnt == W'(1));

    AST_TIMER_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0)); // R5

endmodule

// File: rtl/sram_lane_capture.sv
// Per-lane read-data register.
// An enabled lane takes the bus value when cap is high; a disabled lane
// keeps its previous value.
// Assumes DATA_W is an exact multiple of LANES.
module sram_lane_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int LANE_W = DATA_W / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] q;

        // Capture this lane on the sample cycle if it is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (cap && lane_sel[g])
                q <= din[g*LANE_W +: LANE_W];
        end

        assign dout[g*LANE_W +: LANE_W] = q;
    end

    AST_CAP_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> (lane_sel != '0)); // R3

endmodule

// File: rtl/sram_async_ctrl.sv
// Synchronous controller for an external asynchronous SRAM with byte lanes.
// Strobe outputs are registered and decoded from the next state.
// Phase lengths come from nanosecond parameters rounded up to whole clocks.
// Assumes the host holds address, mask, data and direction stable until the
// acknowledge, and that DATA_W = 8 * LANES.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int LANES     = 2,
    parameter int T_RC_NS   = 15,
    parameter int T_AA_NS   = 15,
    parameter int T_DOE_NS  = 7,
    parameter int T_WC_NS   = 15,
    parameter int T_PWE_NS  = 10,
    parameter int T_SD_NS   = 8,
    parameter int T_AW_NS   = 10,
    parameter int T_SCE_NS  = 10,
    parameter int T_HZWE_NS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_mask,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_lane_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    // Phase lengths in clock cycles.
    localparam int C_AA  = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int C_RD  = imax(imax(C_AA, ns_to_cyc(T_DOE_NS, CLK_NS)),
                                ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int C_HZ  = ns_to_cyc(T_HZWE_NS, CLK_NS);
    localparam int C_PWE = ns_to_cyc(T_PWE_NS, CLK_NS);
    localparam int C_WLO = imax(imax(C_PWE, ns_to_cyc(T_AW_NS, CLK_NS)),
                                imax(ns_to_cyc(T_SCE_NS, CLK_NS),
                                     ns_to_cyc(T_WC_NS, CLK_NS)));
    localparam int C_WD  = imax(imax(ns_to_cyc(T_SD_NS, CLK_NS), C_WLO - C_HZ), 1);
    localparam int C_MAX = imax(C_RD, imax(C_HZ, C_WD));
    localparam int TW    = $clog2(C_MAX + 1);
    localparam int RUN_W = TW + 2;

    ctrl_state_e       st, nxt;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_last;
    logic              drv_en;
    logic [DATA_W-1:0] wdata_q;
    logic              acc_nxt;
    logic              wr_nxt;
    logic              cap;

    // Choose the next phase and the length of the phase being entered.
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_mask == '0) begin
                        nxt = ST_ACK;
                    end else if (host_wr) begin
                        nxt      = ST_WTURN;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(C_HZ);
                    end else begin
                        nxt      = ST_READ;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(C_RD);
                    end
                end
            end
            ST_READ:   if (tmr_last) nxt = ST_ACK;
            ST_WTURN: begin
                if (tmr_last) begin
                    nxt      = ST_WDRIVE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(C_WD);
                end
            end
            ST_WDRIVE: if (tmr_last) nxt = ST_ACK;
            ST_ACK:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Strobe groups implied by the next phase.
    assign acc_nxt = (nxt == ST_READ) || (nxt == ST_WTURN) || (nxt == ST_WDRIVE);
    assign wr_nxt  = (nxt == ST_WTURN) || (nxt == ST_WDRIVE);

    // Register the state and glitch-free memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            mem_ce_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_lane_n <= '1;
            drv_en     <= 1'b0;
            host_ack   <= 1'b0;
        end else begin
            st         <= nxt;
            mem_ce_n   <= !acc_nxt;
            mem_oe_n   <= (nxt != ST_READ);
            mem_we_n   <= !wr_nxt;
            mem_lane_n <= acc_nxt ? ~host_mask : '1;
            drv_en     <= (nxt == ST_WDRIVE);
            host_ack   <= (nxt == ST_ACK);
        end
    end

    // Latch address and write data when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
        end else if (st == ST_IDLE && host_req) begin
            mem_addr <= host_addr;
            wdata_q  <= host_wdata;
        end
    end

    // Drive the shared bus only during the drive phase of a write.
    assign mem_dq = drv_en ? wdata_q : {DATA_W{1'bz}};

    // Sample the bus on the last cycle of a read.
    assign cap = (st == ST_READ) && tmr_last;

    sram_cyc_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_lane_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .lane_sel (~mem_lane_n),
        .din      (mem_dq),
        .dout     (host_rdata)
    );

    // Counters that measure how long the strobes have been low, used by the checks.
    logic [RUN_W-1:0] we_run, rd_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= '0;
            rd_run <= '0;
        end else begin
            we_run <= mem_we_n ? '0 : we_run + 1'b1;
            rd_run <= mem_oe_n ? '0 : rd_run + 1'b1;
        end
    end

    AST_DRV_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!mem_we_n && mem_oe_n && !mem_ce_n)); // R7
    AST_DRV_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (we_run >= RUN_W'(C_HZ))); // R7
    AST_DRV_OFF_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !drv_en); // R7
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= RUN_W'(C_PWE))); // R5
    AST_RD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (rd_run >= RUN_W'(C_AA))); // R6
    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe_n || mem_we_n)); // R9
    AST_RD_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |=> mem_we_n); // R9
    AST_IDLE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> mem_ce_n); // R9
    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && host_req && host_mask == '0) |=> (mem_ce_n && mem_we_n && host_ack)); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R10

endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps

// Behavioural 16-bit SRAM with byte lanes, 256 words (low address bits only).
module sim_sram_model (
    input  logic        clk,
    input  logic [15:0] addr,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [1:0]  lane_n,
    inout  wire  [15:0] dq
);
    logic [7:0] mem_lo [256];
    logic [7:0] mem_hi [256];
    logic       rd;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_lo[i] = i[7:0];
            mem_hi[i] = ~i[7:0];
        end
    end

    assign rd = !ce_n && !oe_n && we_n;
    assign dq[7:0]  = (rd && !lane_n[0]) ? mem_lo[addr[7:0]] : 8'hzz;
    assign dq[15:8] = (rd && !lane_n[1]) ? mem_hi[addr[7:0]] : 8'hzz;

    // The last clock edge inside the write window leaves the final bus value.
    always @(posedge clk) begin
        if (!ce_n && !we_n && !lane_n[0]) mem_lo[addr[7:0]] <= dq[7:0];
        if (!ce_n && !we_n && !lane_n[1]) mem_hi[addr[7:0]] <= dq[15:8];
    end
endmodule

module sim_sram_async_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_mask = '0;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_lane_n;
    wire  [15:0] mem_dq;

    always #2 clk = ~clk;

    sram_async_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
        .host_ack(host_ack), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lane_n(mem_lane_n), .mem_dq(mem_dq)
    );

    sim_sram_model u_mem (
        .clk(clk), .addr(mem_addr), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
        .we_n(mem_we_n), .lane_n(mem_lane_n), .dq(mem_dq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input int act, input int min);
        n_chk++;
        if (act < min) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected >= %0d", tag, act, min);
        end
    endtask

    // Port monitor: strobe widths, bus contents and read-to-write spacing.
    int          we_run = 0, oe_run = 0, since_rd = 100;
    bit          we_ce_bad = 0, oe_bad = 0, prev_we_n = 1;
    logic [15:0] last_dq = '0, cur_wdata = '0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (!mem_we_n) begin
                if (prev_we_n) chk_ge("R9 read-to-write gap", since_rd, 1);
                we_run++;
                if (mem_ce_n) we_ce_bad = 1;
                last_dq = mem_dq;
            end else if (we_run != 0) begin
                chk_ge("R5 write pulse width", we_run, 3);
                chk("R5 chip enable held during write", {31'b0, we_ce_bad}, 32'd0);
                chk("R7 bus data in last write cycle", {16'b0, last_dq}, {16'b0, cur_wdata});
                we_run = 0;
                we_ce_bad = 0;
            end
            if (!mem_oe_n) begin
                oe_run++;
                since_rd = 0;
                if (!mem_we_n || mem_ce_n) oe_bad = 1;
            end else begin
                if (oe_run != 0) begin
                    chk_ge("R6 read strobe width", oe_run, 4);
                    chk("R6 read strobes consistent", {31'b0, oe_bad}, 32'd0);
                    oe_run = 0;
                    oe_bad = 0;
                end
                since_rd++;
            end
        end
        prev_we_n = mem_we_n;
    end

    // One host access; returns read data and number of chip-enable-low cycles.
    task automatic do_op(input logic wr, input logic [1:0] mask, input logic [15:0] addr,
                         input logic [15:0] wdata, output logic [15:0] rdata, output int strobes);
        int cyc;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_mask = mask;
        host_addr = addr; host_wdata = wdata; cur_wdata = wdata;
        strobes = 0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (!mem_ce_n) strobes++;
        end while (!host_ack && cyc < 40);
        chk("R10 acknowledge received", {31'b0, host_ack}, 32'd1);
        rdata = host_rdata;
        host_req = 1'b0;
        @(negedge clk);
        chk("R10 acknowledge lasts one cycle", {31'b0, host_ack}, 32'd0);
        chk("R9 chip enable high when idle", {31'b0, mem_ce_n}, 32'd1);
    endtask

    typedef struct packed {
        logic        wr;
        logic [1:0]  mask;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp;
    } vec_t;

    // Initial content: word i = {~i, i} on its low 8 address bits.
    localparam vec_t VEC [13] = '{
        '{1'b0, 2'b11, 16'h0010, 16'h0000, 16'hEF10}, // R2
        '{1'b1, 2'b11, 16'h0020, 16'h1234, 16'h0000}, // R4 full write
        '{1'b0, 2'b11, 16'h0020, 16'h0000, 16'h1234}, // R2
        '{1'b1, 2'b01, 16'h0020, 16'hABCD, 16'h0000}, // R4 low lane only
        '{1'b0, 2'b11, 16'h0020, 16'h0000, 16'h12CD}, // R4
        '{1'b1, 2'b10, 16'h0021, 16'h5566, 16'h0000}, // R4 high lane only
        '{1'b0, 2'b01, 16'h0021, 16'h0000, 16'h1221}, // R3 high keeps 12
        '{1'b0, 2'b10, 16'h0021, 16'h0000, 16'h5521}, // R3 low keeps 21
        '{1'b1, 2'b00, 16'h0030, 16'hFFFF, 16'h0000}, // R8 no strobes
        '{1'b0, 2'b11, 16'h0030, 16'h0000, 16'hCF30}, // R8 memory untouched
        '{1'b0, 2'b10, 16'h0010, 16'h0000, 16'hEF30}, // R3
        '{1'b1, 2'b11, 16'hC0FF, 16'h0000, 16'h0000}, // R4
        '{1'b0, 2'b11, 16'h00FF, 16'h0000, 16'h0000}  // R2
    };

    initial begin
        logic [15:0] rd;
        int          nstb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ce_n in reset", {31'b0, mem_ce_n}, 32'd1);
        chk("R1 oe_n in reset", {31'b0, mem_oe_n}, 32'd1);
        chk("R1 we_n in reset", {31'b0, mem_we_n}, 32'd1);
        chk("R1 lanes in reset", {30'b0, mem_lane_n}, 32'd3);
        chk("R1 ack in reset", {31'b0, host_ack}, 32'd0);
        chk("R1 rdata in reset", {16'b0, host_rdata}, 32'd0);
        rst_n = 1'b1;
        mon_en = 1'b1;

        for (int i = 0; i < 13; i++) begin
            do_op(VEC[i].wr, VEC[i].mask, VEC[i].addr, VEC[i].wdata, rd, nstb);
            if (VEC[i].mask == 2'b00)
                chk("R8 zero mask strobes", nstb, 0);
            else
                chk_ge("R4 access strobes present", nstb, 1);
            if (!VEC[i].wr) begin
                if (VEC[i].mask != 2'b11)
                    chk("R3 lane-masked read data", {16'b0, rd}, {16'b0, VEC[i].exp});
                else
                    chk("R2 read data", {16'b0, rd}, {16'b0, VEC[i].exp});
            end
        end

        // R1 reset during a write aborts all strobes.
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_mask = 2'b11;
        host_addr = 16'h0040; host_wdata = 16'h7777;
        repeat (3) @(negedge clk);
        chk("R1 write under way before reset", {31'b0, mem_we_n}, 32'd0);
        mon_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 we_n after reset", {31'b0, mem_we_n}, 32'd1);
        chk("R1 ce_n after reset", {31'b0, mem_ce_n}, 32'd1);
        chk("R1 lanes after reset", {30'b0, mem_lane_n}, 32'd3);
        chk("R1 rdata after reset", {16'b0, host_rdata}, 32'd0);
        host_req = 1'b0;
        we_run = 0; oe_run = 0; we_ce_bad = 0; oe_bad = 0; since_rd = 100;
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        // R2 recovery read after the aborted write
        do_op(1'b0, 2'b11, 16'h0010, 16'h0000, rd, nstb);
        chk("R2 read after reset", {16'b0, rd}, 32'h0000EF10);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule